// File: doc/BRIEF.md
# Multiplexed registered bus transceiver

This block joins one narrow A-side bus to four B-side buses of the same width. In the B-to-A direction, each B bus first passes through its own storage stage. A binary select then picks one of the four stored values and feeds it through a final output stage onto A. In the A-to-B direction, the A bus fans out to four storage stages, one for each B bus. A single shared active-low clock enable loads these stages, and a 2-bit steering field sends that enable to exactly one of them, so the four B ports can be loaded one at a time from a single source.

Every storage stage is a hybrid cell. While its latch-enable is high, the cell is transparent: its output follows its input in the same cycle, and the clock has no effect. While its latch-enable is low, the cell holds its value. It takes a new value on a rising clock edge only when its clock enable is asserted.

Each bidirectional pin is modelled as a separate input, an output and an output-enable. A disabled output drives zero. The B outputs are controlled either as one 16-bit group or as four independent 4-bit groups. Storage keeps operating whatever the output enables are set to.

Top module: `mux_xcvr_top`

## Requirements
- R1: When an A-to-B latch-enable `ab_le[i]` is high, that port's B output equals `a_in` in the same cycle, and clock edges do not alter it.
- R2: A cell whose latch-enable is low, and whose clock enable is deasserted at an edge, keeps the value it held at the last edge when it was transparent or clocked.
- R3: With `ab_le[i]` low, `clk_en_n` low and `ce_route` equal to i (0 = B1 … 3 = B4), cell i captures `a_in` on the rising edge. The other three A-to-B cells do not capture.
- R4: Each B-to-A input cell i is transparent to its B input while `ba_le[i]` is high. While `ba_le[i]` is low, it captures that input on every edge where `clk_en_n` is low. This enable is not steered.
- R5: `a_sel` (0 = B1 … 3 = B4) chooses which B-to-A input cell feeds the output stage.
- R6: The output stage is transparent while `out_le` is high. While `out_le` is low, it captures the selected value on edges where `clk_en_n` is low.
- R7: When `a_oe_n` is low, `a_oe` is 1 and `a_out` carries the output stage. When `a_oe_n` is high, `a_oe` is 0 and `a_out` is 0.
- R8: When `b_grp_oe_n` is low, all four `b_oe` bits are 1 and `b_oe_n` is ignored. When it is high, `b_oe[i]` = not `b_oe_n[i]`. A disabled B port (bits `i*4+3:i*4` of `b_out`) drives 0.
- R9: Output enables do not affect storage. Values captured while outputs are disabled appear once the outputs are enabled.
- R10: A rising edge with `rst_n` low clears every stored value to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Storage clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| a_in | input | 4 | A-side input value |
| a_out | output | 4 | A-side driven value (0 when disabled) |
| a_oe | output | 1 | A-side output enable, active high |
| b_in | input | 16 | B-side inputs, port i in bits i*4+3:i*4 |
| b_out | output | 16 | B-side driven values, same packing |
| b_oe | output | 4 | Per-port B output enables, active high |
| ab_le | input | 4 | A-to-B latch-enables, one per B port |
| ba_le | input | 4 | B-to-A input latch-enables |
| out_le | input | 1 | B-to-A output-stage latch-enable |
| clk_en_n | input | 1 | Shared active-low clock enable |
| ce_route | input | 2 | Steers the clock enable to one A-to-B cell |
| a_sel | input | 2 | Selects the B-to-A cell that feeds A |
| a_oe_n | input | 1 | A output enable, active low |
| b_grp_oe_n | input | 1 | Low: all B ports enabled as one group |
| b_oe_n | input | 4 | Per-port B output enables, active low |

## Verification
The paths differ in when their results appear. A transparent path and every output-enable effect show up in the same cycle, before any edge. A captured value appears one edge after the cycle in which its load condition was present. A held value must still be there one or more edges later. Because of this, the bench changes inputs just after a rising edge, lets them settle, and compares every output against a reference model. The model advances its stored values only at the edge, using the inputs that were present before it. As a result, each combinational result is checked in the cycle it is driven, and each registered result is checked in the cycle after its edge.

// File: rtl/mux_xcvr_pkg.sv
// Package: shared sizing for the multiplexed registered transceiver.
// Assumes the B-side port count is a power of two so selects decode fully.
package mux_xcvr_pkg;
    localparam int XC_W  = 4;   // bits per port
    localparam int XC_NB = 4;   // number of B-side ports
endpackage

// File: rtl/mx_store_cell.sv
// Hybrid storage cell: a transparent latch while le is high, otherwise a
// clock-enabled register. The latch is modelled synchronously: while le is
// high the register tracks d at every edge, so after le falls the cell
// holds the input present at the last edge. Assumes d is stable around the
// falling of le.
module mx_store_cell #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    input  logic         le,
    input  logic         ce_n,
    output logic [W-1:0] q
);
    logic [W-1:0] held;

    // Track while transparent, load on enabled edge, clear on reset.
    always_ff @(posedge clk) begin
        if (!rst_n)
            held <= '0;
        else if (le || !ce_n)
            held <= d;
    end

    // Transparent path bypasses the stored value.
    always_comb q = le ? d : held;
endmodule

// File: rtl/mx_ce_steer.sv
// Clock-enable steering: routes one active-low enable to the cell whose
// index equals route; every other cell sees the enable deasserted.
module mx_ce_steer #(
    parameter int NB = 4,
    localparam int SW = $clog2(NB)
) (
    input  logic          ce_n,
    input  logic [SW-1:0] route,
    output logic [NB-1:0] ce_n_vec
);
    // Decode route into a one-cold enable vector.
    always_comb begin
        for (int i = 0; i < NB; i++)
            ce_n_vec[i] = ce_n || (route != SW'(i));
    end
endmodule

// File: rtl/mx_out_gate.sv
// Output gate: presents data with an active-high enable; a disabled output
// drives zero as the synthesizable stand-in for high impedance.
module mx_out_gate #(
    parameter int W = 4
) (
    input  logic         en,
    input  logic [W-1:0] d,
    output logic [W-1:0] q,
    output logic         oe
);
    // Zero the data when not enabled.
    always_comb begin
        oe = en;
        q  = en ? d : '0;
    end
endmodule

// File: rtl/mux_xcvr_top.sv
// Multiplexed registered transceiver: one A bus to NB B buses. A-to-B
// stages share one steered clock enable; B-to-A stages feed a select and
// a final output stage. Assumes synchronous reset and a single clock.
module mux_xcvr_top
    import mux_xcvr_pkg::*;
#(
    parameter int W  = XC_W,
    parameter int NB = XC_NB,
    localparam int SW = $clog2(NB)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [W-1:0]    a_in,
    output logic [W-1:0]    a_out,
    output logic            a_oe,
    input  logic [NB*W-1:0] b_in,
    output logic [NB*W-1:0] b_out,
    output logic [NB-1:0]   b_oe,
    input  logic [NB-1:0]   ab_le,
    input  logic [NB-1:0]   ba_le,
    input  logic            out_le,
    input  logic            clk_en_n,
    input  logic [SW-1:0]   ce_route,
    input  logic [SW-1:0]   a_sel,
    input  logic            a_oe_n,
    input  logic            b_grp_oe_n,
    input  logic [NB-1:0]   b_oe_n
);
    logic [NB-1:0] ab_ce_n;
    logic [W-1:0]  ab_q [NB];
    logic [W-1:0]  ba_q [NB];
    logic [W-1:0]  sel_d;
    logic [W-1:0]  out_q;

    mx_ce_steer #(.NB(NB)) u_steer (
        .ce_n     (clk_en_n),
        .route    (ce_route),
        .ce_n_vec (ab_ce_n)
    );

    for (genvar i = 0; i < NB; i++) begin : g_port
        logic b_en;

        mx_store_cell #(.W(W)) u_ab (
            .clk (clk), .rst_n (rst_n), .d (a_in),
            .le (ab_le[i]), .ce_n (ab_ce_n[i]), .q (ab_q[i])
        );

        mx_store_cell #(.W(W)) u_ba (
            .clk (clk), .rst_n (rst_n), .d (b_in[i*W +: W]),
            .le (ba_le[i]), .ce_n (clk_en_n), .q (ba_q[i])
        );

        // Group mode enables every port; otherwise per-port control.
        always_comb b_en = !b_grp_oe_n || !b_oe_n[i];

        mx_out_gate #(.W(W)) u_bgate (
            .en (b_en), .d (ab_q[i]),
            .q (b_out[i*W +: W]), .oe (b_oe[i])
        );
    end

    // Pick the B-to-A stage named by a_sel.
    always_comb sel_d = ba_q[a_sel];

    mx_store_cell #(.W(W)) u_out (
        .clk (clk), .rst_n (rst_n), .d (sel_d),
        .le (out_le), .ce_n (clk_en_n), .q (out_q)
    );

    mx_out_gate #(.W(W)) u_agate (
        .en (!a_oe_n), .d (out_q), .q (a_out), .oe (a_oe)
    );
endmodule

// File: rtl/mux_xcvr_chk.sv
// Checker for mux_xcvr_top: relates port behaviour over time.
// Assumes the same parameters as the module it is bound to.
module mux_xcvr_chk #(
    parameter int W  = 4,
    parameter int NB = 4,
    localparam int SW = $clog2(NB)
) (
    input logic            clk,
    input logic            rst_n,
    input logic [W-1:0]    a_in,
    input logic [W-1:0]    a_out,
    input logic            a_oe,
    input logic [NB*W-1:0] b_in,
    input logic [NB*W-1:0] b_out,
    input logic [NB-1:0]   b_oe,
    input logic [NB-1:0]   ab_le,
    input logic [NB-1:0]   ba_le,
    input logic            out_le,
    input logic            clk_en_n,
    input logic [SW-1:0]   ce_route,
    input logic [SW-1:0]   a_sel,
    input logic            a_oe_n,
    input logic            b_grp_oe_n,
    input logic [NB-1:0]   b_oe_n
);
    p_a_gate_r7: assert property (@(posedge clk) disable iff (!rst_n)
        a_oe_n |-> (!a_oe && a_out == '0));

    p_group_oe_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !b_grp_oe_n |-> (b_oe == '1));

    p_out_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(!out_le && clk_en_n && !a_oe_n)
         && !out_le && !a_oe_n) |-> $stable(a_out));

    for (genvar i = 0; i < NB; i++) begin : g_chk
        p_transparent_r1: assert property (@(posedge clk) disable iff (!rst_n)
            (ab_le[i] && b_oe[i]) |-> (b_out[i*W +: W] == a_in));

        p_capture_r3: assert property (@(posedge clk) disable iff (!rst_n)
            ($past(rst_n) && $past(!ab_le[i] && !clk_en_n && ce_route == SW'(i))
             && !ab_le[i] && b_oe[i]) |-> (b_out[i*W +: W] == $past(a_in)));

        p_disabled_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
            !b_oe[i] |-> (b_out[i*W +: W] == '0));
    end
endmodule

bind mux_xcvr_top mux_xcvr_chk #(.W(W), .NB(NB)) u_chk (.*);

// File: tb/tb_mux_xcvr_top.sv
`timescale 1ns/100ps
module tb_mux_xcvr_top;
    localparam int W = 4;
    localparam int NB = 4;

    logic            clk = 1'b0;
    logic            rst_n;
    logic [W-1:0]    a_in;
    logic [W-1:0]    a_out;
    logic            a_oe;
    logic [NB*W-1:0] b_in;
    logic [NB*W-1:0] b_out;
    logic [NB-1:0]   b_oe;
    logic [NB-1:0]   ab_le, ba_le, b_oe_n;
    logic            out_le, clk_en_n, a_oe_n, b_grp_oe_n;
    logic [1:0]      ce_route, a_sel;

    int n_tests = 0;
    int n_fail  = 0;

    // Reference model state
    logic [W-1:0] m_ab [NB];
    logic [W-1:0] m_ba [NB];
    logic [W-1:0] m_out;

    always #2.5 clk = ~clk;

    mux_xcvr_top dut (.*);

    function automatic logic [W-1:0] ba_view(int i);
        return ba_le[i] ? b_in[i*W +: W] : m_ba[i];
    endfunction

    function automatic logic [W-1:0] out_view();
        logic [W-1:0] s;
        s = ba_view(int'(a_sel));
        return out_le ? s : m_out;
    endfunction

    // Advance one clock edge, updating the model from pre-edge inputs.
    task automatic step();
        logic [W-1:0] n_ab [NB];
        logic [W-1:0] n_ba [NB];
        logic [W-1:0] n_out;
        for (int i = 0; i < NB; i++) begin
            n_ab[i] = (ab_le[i] || (!clk_en_n && int'(ce_route) == i)) ? a_in : m_ab[i];
            n_ba[i] = (ba_le[i] || !clk_en_n) ? b_in[i*W +: W] : m_ba[i];
        end
        n_out = (out_le || !clk_en_n) ? ba_view(int'(a_sel)) : m_out;
        if (!rst_n) begin
            for (int i = 0; i < NB; i++) begin n_ab[i] = '0; n_ba[i] = '0; end
            n_out = '0;
        end
        @(posedge clk);
        #1;
        m_ab = n_ab; m_ba = n_ba; m_out = n_out;
    endtask

    task automatic chk(string tag, string what, logic [31:0] got, logic [31:0] exp);
        n_tests++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s %s: got %0h expected %0h", tag, what, got, exp);
        end
    endtask

    // Compare every output against the model after inputs settle.
    task automatic check_all(string tag);
        logic [NB*W-1:0] eb;
        logic [NB-1:0]   eoe;
        #0.5;
        for (int i = 0; i < NB; i++) begin
            eoe[i] = !b_grp_oe_n || !b_oe_n[i];
            eb[i*W +: W] = eoe[i] ? (ab_le[i] ? a_in : m_ab[i]) : '0;
        end
        chk(tag, "b_out", 32'(b_out), 32'(eb));
        chk(tag, "b_oe", 32'(b_oe), 32'(eoe));
        chk(tag, "a_oe", 32'(a_oe), 32'(!a_oe_n));
        chk(tag, "a_out", 32'(a_out), a_oe_n ? 32'h0 : 32'(out_view()));
    endtask

    initial begin
        #100000;
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        logic [15:0] lfsr;
        for (int i = 0; i < NB; i++) begin m_ab[i] = 'x; m_ba[i] = 'x; end
        m_out = 'x;
        rst_n = 0; a_in = 4'h9; b_in = 16'h1234; ab_le = '0; ba_le = '0;
        out_le = 0; clk_en_n = 1; ce_route = 0; a_sel = 0;
        a_oe_n = 0; b_grp_oe_n = 0; b_oe_n = '1;
        #1;
        step(); step();
        check_all("R10 reset clears");
        rst_n = 1;
        step();
        check_all("R10 after reset");

        // R1 transparency across all A values
        ab_le = '1;
        for (int v = 0; v < 16; v++) begin
            a_in = 4'(v);
            check_all("R1 transparent");
        end
        step();
        check_all("R1 edge no effect");

        // R3 steered capture, one port at a time
        ab_le = '0; clk_en_n = 0;
        for (int i = 0; i < NB; i++) begin
            ce_route = 2'(i); a_in = 4'(i + 5);
            step();
            check_all("R3 steered capture");
        end

        // R2 hold with clock enable deasserted
        clk_en_n = 1; a_in = 4'hF;
        step(); step();
        check_all("R2 hold A-to-B");

        // R4 and R5: transparent B-to-A, sweep selects
        ba_le = '1; out_le = 1; b_in = 16'hC3A5;
        for (int s = 0; s < NB; s++) begin
            a_sel = 2'(s);
            check_all("R5 select");
        end
        // R4 latch and clocked capture
        step();
        ba_le = '0; b_in = 16'h7E81;
        step();
        check_all("R4 held B-to-A");
        clk_en_n = 0;
        step();
        check_all("R4 clocked B-to-A");

        // R6 output stage capture then hold
        out_le = 0; a_sel = 2;
        step();
        check_all("R6 out capture");
        clk_en_n = 1; a_sel = 1; b_in = 16'h0000;
        step();
        check_all("R6 out hold");

        // R7 A gate
        a_oe_n = 1;
        check_all("R7 A disabled");
        a_oe_n = 0;
        check_all("R7 A enabled");

        // R8 enable modes
        b_grp_oe_n = 0; b_oe_n = '1;
        check_all("R8 group mode");
        b_grp_oe_n = 1;
        for (int m = 0; m < 16; m++) begin
            b_oe_n = 4'(m);
            check_all("R8 per-port");
        end

        // R9 storage with outputs disabled
        b_oe_n = '1; a_oe_n = 1; clk_en_n = 0; ce_route = 3; a_in = 4'hB;
        ba_le = '0; out_le = 0; b_in = 16'h5D2E; a_sel = 3;
        step(); step();
        clk_en_n = 1; b_oe_n = '0; a_oe_n = 0;
        check_all("R9 storage while disabled");

        // Sweep with pseudo-random stimulus against the model
        lfsr = 16'hACE1;
        for (int c = 0; c < 3000; c++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            a_in = lfsr[3:0]; b_in = {lfsr[7:0], lfsr[15:8]};
            ab_le = (lfsr[2:0] == 0) ? lfsr[11:8] : '0;
            ba_le = (lfsr[5:3] == 0) ? lfsr[15:12] : '0;
            out_le = (lfsr[9:7] == 0);
            clk_en_n = lfsr[6];
            ce_route = lfsr[14:13]; a_sel = lfsr[1:0];
            a_oe_n = (lfsr[4:2] == 7); b_grp_oe_n = lfsr[10];
            b_oe_n = lfsr[12:9];
            rst_n = (lfsr[15:11] != 0);
            check_all("R3 R6 sweep");
            step();
        end

        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule